// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a 4 KiB window of 32-bit control and status words behind a simple single-cycle memory-mapped bus. Software must first write a magic word to the key register to unlock the bank. Some registers set bits on write and have a companion address one word above that clears bits. Strap words can be write-protected by a guard word two words above them. Read-only words hold the revision and the chip identity. PLL extension words always read as locked. A random word returns the next output of an LFSR on every read.

A request is taken when `bus_valid` is high at a rising clock edge. A write takes effect at that edge. A read result appears on `rd_data` with `rd_valid` high for one cycle after it. A small phase machine tracks the last access. PH_IDLE moves to PH_READ on a read request, to PH_WRITE on a write request, and stays in PH_IDLE when there is no request. PH_READ and PH_WRITE leave by the same three transitions, so each phase lasts exactly one cycle unless another request of the same type follows. `rd_valid` is high only in PH_READ. At reset the revision, the two strap words and the key flag are captured from input ports.

Top module: `keyed_sysctl_bank`

## Requirements
- R1: A write to offset 0x000 stores 1 when the data equals KEY_MAGIC (default 0x5A17C3E9) and 0 otherwise. A read of 0x000 returns that flag in bit 0, with bits 31:1 zero.
- R2: Writes to the set words at 0x040, 0x050, 0x080 and 0x090 OR the data into the stored value.
- R3: A write to the clear address one word above a set word (0x044, 0x054, 0x084, 0x094) ANDs the inverted data into the set word. The clear address itself reads 0.
- R4: The strap words at 0x500 and 0x510 set bits on write, and their clear addresses are 0x504 and 0x514. A set write is dropped while the guard word two words above (0x508 or 0x518) is nonzero. Clear writes are never blocked by the guard word.
- R5: Reads of 0x204, 0x224 and 0x244 return the stored word with bit 31 forced to 1.
- R6: Each read of 0x540 returns the current state of a 32-bit Galois LFSR and then advances it once. The LFSR is seeded with LFSR_SEED (default 1) at reset and shifts right, XORing 0x80200003 when the bit shifted out is 1. The enable word at 0x524 does not affect this.
- R7: Writes to 0x004, 0x014, 0x5B0, 0x5B4, 0x540 and 0x5F0 are ignored.
- R8: Reset values are 0x040=F7C3FED8, 0x050=FFFFFFFC, 0x080=FFFF7F8A, 0x090=FFF0FFF0, 0x100=00000040, 0x200=1000405F, 0x5B0=1234ABCD and 0x5B4=88884444. All other words reset to 0.
- R9: At reset, 0x004 and 0x014 load `silicon_rev_in`, 0x500 loads `strap1_in`, 0x510 loads `strap2_in`, and the key flag loads `key_state_in`.
- R10: An access whose low two address bits are not 00, or whose word lies at 0x600 or above, reads 0. A write of either kind changes nothing.
- R11: A write to any in-range aligned word other than 0x000 while the key flag is 0 sets a sticky error bit, read as bit 0 of 0x5F0. The write still takes effect. Writes to 0x000 never set this bit. The bit clears only on reset.
- R12: Other in-range words store the written data. `rd_valid` and `rd_data` are valid in the cycle after a read request, and `rd_valid` is 0 after reset and after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| silicon_rev_in | input | 32 | Revision captured at reset |
| strap1_in | input | 32 | First strap word captured at reset |
| strap2_in | input | 32 | Second strap word captured at reset |
| key_state_in | input | 1 | Key flag captured at reset |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |

## Verification
A write changes state at the edge that takes it, so a read issued in the next cycle already sees the new value. A read result, including the LFSR value and the forced PLL lock bit, is registered at the edge that takes the read and is due one cycle after the request. The bench drives each request on a falling edge, lets one rising edge pass, and compares `rd_data` at the following falling edge. The sticky error bit and the LFSR advance are checked with the same one-cycle spacing.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int DATA_W = 32;

    // word indices (byte offset / 4); positions the access rules depend on
    localparam int W_KEY    = 0;
    localparam int W_REV0   = 1;
    localparam int W_REV1   = 5;
    localparam int W_RST0   = 16;
    localparam int W_RST1   = 20;
    localparam int W_GATE0  = 32;
    localparam int W_GATE1  = 36;
    localparam int W_HSHAKE = 64;
    localparam int W_PLL_P  = 128;
    localparam int W_PLL_H  = 129;
    localparam int W_PLL_M  = 137;
    localparam int W_PLL_E  = 145;
    localparam int W_STRAP1 = 320;
    localparam int W_STRAP2 = 324;
    localparam int W_RNGCTL = 329;
    localparam int W_RAND   = 336;
    localparam int W_CHIP0  = 364;
    localparam int W_CHIP1  = 365;
    localparam int W_STATUS = 380;

    typedef enum logic [3:0] {
        K_PLAIN,
        K_KEY,
        K_SET,
        K_CLR,
        K_STRAP_SET,
        K_STRAP_CLR,
        K_PLL,
        K_RO,
        K_RAND,
        K_STATUS,
        K_OOR,
        K_MIS
    } acc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_READ,
        PH_WRITE
    } phase_e;

    function automatic logic [DATA_W-1:0] reset_word(input int w);
        case (w)
            W_RST0:   return 32'hF7C3_FED8;
            W_RST1:   return 32'hFFFF_FFFC;
            W_GATE0:  return 32'hFFFF_7F8A;
            W_GATE1:  return 32'hFFF0_FFF0;
            W_HSHAKE: return 32'h0000_0040;
            W_PLL_P:  return 32'h1000_405F;
            W_CHIP0:  return 32'h1234_ABCD;
            W_CHIP1:  return 32'h8888_4444;
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/scb_decode.sv
module scb_decode
    import scb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int REG_WORDS = 384,
    localparam int WORD_W   = ADDR_W - 2,
    localparam int IDX_W    = $clog2(REG_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [WORD_W-1:0] LIMIT = WORD_W'(REG_WORDS);

    logic [WORD_W-1:0] word;
    int                widx;

    assign word = addr[ADDR_W-1:2];
    assign idx  = word[IDX_W-1:0];

    always_comb begin
        widx = int'(idx);
        if (addr[1:0] != 2'b00) begin
            kind = K_MIS;
        end else if (word >= LIMIT) begin
            kind = K_OOR;
        end else begin
            case (widx)
                W_KEY:                                    kind = K_KEY;
                W_REV0, W_REV1, W_CHIP0, W_CHIP1:         kind = K_RO;
                W_RAND:                                   kind = K_RAND;
                W_STATUS:                                 kind = K_STATUS;
                W_RST0, W_RST1, W_GATE0, W_GATE1:         kind = K_SET;
                W_RST0 + 1, W_RST1 + 1,
                W_GATE0 + 1, W_GATE1 + 1:                 kind = K_CLR;
                W_STRAP1, W_STRAP2:                       kind = K_STRAP_SET;
                W_STRAP1 + 1, W_STRAP2 + 1:               kind = K_STRAP_CLR;
                W_PLL_H, W_PLL_M, W_PLL_E:                kind = K_PLL;
                default:                                  kind = K_PLAIN;
            endcase
        end
    end

endmodule

// File: rtl/scb_lfsr.sv
module scb_lfsr #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] TAPS  = 32'h8020_0003,
    parameter logic [WIDTH-1:0] SEED  = 32'h0000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] next_state;

    always_comb begin
        next_state = state >> 1;
        if (state[0]) next_state = next_state ^ TAPS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= SEED;
        else if (step) state <= next_state;
    end

    assert_lfsr_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    assert_lfsr_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> state != $past(state));

endmodule

// File: rtl/scb_regfile.sv
module scb_regfile
    import scb_pkg::*;
#(
    parameter int               REG_WORDS = 384,
    parameter logic [31:0]      KEY_MAGIC = 32'h5A17_C3E9,
    localparam int              IDX_W     = $clog2(REG_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  acc_kind_e        kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic [31:0]      rev_in,
    input  logic [31:0]      strap1_in,
    input  logic [31:0]      strap2_in,
    input  logic             key_in,
    output logic [31:0]      rd_word,
    output logic             key_flag,
    output logic             lock_err
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
    localparam logic [IDX_W-1:0] TWO = IDX_W'(2);

    logic [31:0] mem [REG_WORDS];
    logic        in_bank;
    logic [31:0] guard_word;

    assign in_bank    = int'(idx) < REG_WORDS;
    assign rd_word    = in_bank ? mem[idx] : '0;
    assign key_flag   = mem[W_KEY][0];
    assign guard_word = (int'(idx) + 2 < REG_WORDS) ? mem[idx + TWO] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_WORDS; i++) mem[i] <= reset_word(i);
            mem[W_REV0]   <= rev_in;
            mem[W_REV1]   <= rev_in;
            mem[W_STRAP1] <= strap1_in;
            mem[W_STRAP2] <= strap2_in;
            mem[W_KEY]    <= {31'b0, key_in};
        end else if (we) begin
            case (kind)
                K_KEY:       mem[W_KEY] <= {31'b0, wdata == KEY_MAGIC};
                K_SET:       mem[idx] <= mem[idx] | wdata;
                K_CLR,
                K_STRAP_CLR: mem[idx - ONE] <= mem[idx - ONE] & ~wdata;
                K_STRAP_SET: if (guard_word == '0) mem[idx] <= mem[idx] | wdata;
                K_PLAIN,
                K_PLL:       mem[idx] <= wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_err <= 1'b0;
        end else if (we && !key_flag && kind != K_KEY && kind != K_OOR && kind != K_MIS) begin
            lock_err <= 1'b1;
        end
    end

    assert_key_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == K_KEY) |=> key_flag == ($past(wdata) == KEY_MAGIC));

    assert_key_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem[W_KEY][31:1] == '0);

    assert_strap_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == K_STRAP_SET && int'(idx) == W_STRAP1 && mem[W_STRAP1 + 2] != '0)
        |=> $stable(mem[W_STRAP1]));

    assert_chip_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(idx) == W_CHIP0) |=> $stable(mem[W_CHIP0]));

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |=> lock_err);

endmodule

// File: rtl/keyed_sysctl_bank.sv
module keyed_sysctl_bank
    import scb_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          REG_WORDS = 384,
    parameter logic [31:0] KEY_MAGIC = 32'h5A17_C3E9,
    parameter logic [31:0] LFSR_SEED = 32'h0000_0001,
    parameter logic [31:0] LFSR_TAPS = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [31:0]       silicon_rev_in,
    input  logic [31:0]       strap1_in,
    input  logic [31:0]       strap2_in,
    input  logic              key_state_in,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);

    localparam int IDX_W = $clog2(REG_WORDS);

    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             rd_req;
    logic             wr_req;
    logic [31:0]      rd_word;
    logic             key_flag;
    logic             lock_err;
    logic [31:0]      rnd;
    logic [31:0]      rd_mux;
    logic [31:0]      rd_data_q;
    phase_e           phase_q;
    phase_e           phase_d;

    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid && bus_write;

    scb_decode #(.ADDR_W(ADDR_W), .REG_WORDS(REG_WORDS)) u_decode (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    scb_regfile #(.REG_WORDS(REG_WORDS), .KEY_MAGIC(KEY_MAGIC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_req),
        .kind      (kind),
        .idx       (idx),
        .wdata     (bus_wdata),
        .rev_in    (silicon_rev_in),
        .strap1_in (strap1_in),
        .strap2_in (strap2_in),
        .key_in    (key_state_in),
        .rd_word   (rd_word),
        .key_flag  (key_flag),
        .lock_err  (lock_err)
    );

    scb_lfsr #(.WIDTH(32), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_rng (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rd_req && kind == K_RAND),
        .state (rnd)
    );

    always_comb begin
        unique case (kind)
            K_KEY:        rd_mux = {31'b0, key_flag};
            K_PLL:        rd_mux = rd_word | 32'h8000_0000;
            K_RAND:       rd_mux = rnd;
            K_STATUS:     rd_mux = {31'b0, lock_err};
            K_OOR, K_MIS: rd_mux = '0;
            default:      rd_mux = rd_word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data_q <= '0;
        else if (rd_req) rd_data_q <= rd_mux;
    end

    // phase machine: next-state logic
    always_comb begin
        unique case (phase_q)
            PH_IDLE, PH_READ, PH_WRITE: begin
                if (rd_req)      phase_d = PH_READ;
                else if (wr_req) phase_d = PH_WRITE;
                else             phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // phase machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // phase machine: outputs
    always_comb begin
        rd_valid = 1'b0;
        unique case (phase_q)
            PH_READ:  rd_valid = 1'b1;
            default:  rd_valid = 1'b0;
        endcase
        rd_data = rd_data_q;
    end

    assert_pll_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && kind == K_PLL) |=> rd_data[31]);

    assert_rd_due_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_wr_no_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !rd_valid);

    assert_bad_addr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (kind == K_OOR || kind == K_MIS)) |=> rd_data == '0);

endmodule

// File: tb/keyed_sysctl_bank_bench.sv
`timescale 1ns/100ps
module keyed_sysctl_bank_bench;

    localparam logic [31:0] MAGIC = 32'h5A17_C3E9;
    localparam logic [31:0] REV   = 32'h0503_0303;
    localparam logic [31:0] ST1   = 32'h0000_00F0;
    localparam logic [31:0] ST2   = 32'h0000_0001;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 47;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 12'h000, 32'h0000_0001, 8'd9},   // R9 key flag from input
        '{1'b0, 12'h004, REV,           8'd9},   // R9 revision
        '{1'b0, 12'h014, REV,           8'd9},   // R9 second revision
        '{1'b0, 12'h040, 32'hF7C3_FED8, 8'd8},   // R8
        '{1'b0, 12'h050, 32'hFFFF_FFFC, 8'd8},   // R8
        '{1'b0, 12'h080, 32'hFFFF_7F8A, 8'd8},   // R8
        '{1'b0, 12'h090, 32'hFFF0_FFF0, 8'd8},   // R8
        '{1'b0, 12'h100, 32'h0000_0040, 8'd8},   // R8
        '{1'b0, 12'h200, 32'h1000_405F, 8'd8},   // R8
        '{1'b0, 12'h5B0, 32'h1234_ABCD, 8'd8},   // R8
        '{1'b0, 12'h5B4, 32'h8888_4444, 8'd8},   // R8
        '{1'b0, 12'h300, 32'h0000_0000, 8'd8},   // R8 other words zero
        '{1'b0, 12'h500, ST1,           8'd9},   // R9 strap1
        '{1'b0, 12'h510, ST2,           8'd9},   // R9 strap2
        '{1'b0, 12'h5F0, 32'h0000_0000, 8'd11},  // R11 no error yet
        '{1'b1, 12'h040, 32'h0800_0000, 8'd2},
        '{1'b0, 12'h040, 32'hFFC3_FED8, 8'd2},   // R2 OR in
        '{1'b1, 12'h044, 32'h0000_FF00, 8'd3},
        '{1'b0, 12'h040, 32'hFFC3_00D8, 8'd3},   // R3 clear alias
        '{1'b0, 12'h044, 32'h0000_0000, 8'd3},   // R3 alias reads 0
        '{1'b1, 12'h054, 32'hFFFF_FFFF, 8'd3},
        '{1'b0, 12'h050, 32'h0000_0000, 8'd3},   // R3
        '{1'b1, 12'h050, 32'h0000_0005, 8'd2},
        '{1'b0, 12'h050, 32'h0000_0005, 8'd2},   // R2
        '{1'b1, 12'h500, 32'h0000_0F00, 8'd4},
        '{1'b0, 12'h500, 32'h0000_0FF0, 8'd4},   // R4 set unguarded
        '{1'b1, 12'h508, 32'h0000_0001, 8'd4},
        '{1'b1, 12'h500, 32'hF000_0000, 8'd4},
        '{1'b0, 12'h500, 32'h0000_0FF0, 8'd4},   // R4 set blocked
        '{1'b1, 12'h504, 32'h0000_00F0, 8'd4},
        '{1'b0, 12'h500, 32'h0000_0F00, 8'd4},   // R4 clear not blocked
        '{1'b1, 12'h510, 32'h0000_0002, 8'd4},
        '{1'b0, 12'h510, 32'h0000_0003, 8'd4},   // R4 strap2
        '{1'b0, 12'h204, 32'h8000_0000, 8'd5},   // R5 lock forced
        '{1'b1, 12'h224, 32'h0000_1234, 8'd5},
        '{1'b0, 12'h224, 32'h8000_1234, 8'd5},   // R5
        '{1'b1, 12'h004, 32'hFFFF_FFFF, 8'd7},
        '{1'b0, 12'h004, REV,           8'd7},   // R7 revision RO
        '{1'b1, 12'h5B0, 32'h0000_0000, 8'd7},
        '{1'b0, 12'h5B0, 32'h1234_ABCD, 8'd7},   // R7 chip id RO
        '{1'b1, 12'h300, 32'hDEAD_BEEF, 8'd12},
        '{1'b0, 12'h300, 32'hDEAD_BEEF, 8'd12},  // R12 plain store
        '{1'b0, 12'h600, 32'h0000_0000, 8'd10},  // R10 beyond bank
        '{1'b1, 12'h302, 32'h0000_0000, 8'd10},
        '{1'b0, 12'h300, 32'hDEAD_BEEF, 8'd10},  // R10 misaligned write dropped
        '{1'b0, 12'h302, 32'h0000_0000, 8'd10},  // R10 misaligned read 0
        '{1'b1, 12'h600, 32'h1111_1111, 8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        key_state_in = 1'b1;
    logic        rd_valid;
    logic [31:0] rd_data;
    int          n_checks = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic [31:0] model;

    always #2.5 clk = ~clk;

    keyed_sysctl_bank u_keyed_sysctl_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_valid      (bus_valid),
        .bus_write      (bus_write),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .silicon_rev_in (REV),
        .strap1_in      (ST1),
        .strap2_in      (ST2),
        .key_state_in   (key_state_in),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data)
    );

    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int r);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %08h expected %08h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input int r);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check({31'b0, rd_valid}, 32'h1, 12);
        check(rd_data, exp, r);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check({31'b0, rd_valid}, 32'h0, 12);   // R12 no valid after reset
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else           rd(VEC[i].addr, VEC[i].data, int'(VEC[i].req));
        end
        check({31'b0, rd_valid}, 32'h0, 12);   // R12 no valid after write

        // R1 key behaviour and R11 lock error
        wr(12'h000, MAGIC ^ 32'h1);
        rd(12'h000, 32'h0, 1);                  // R1 wrong key locks
        rd(12'h5F0, 32'h0, 11);                 // R11 key write raises nothing
        wr(12'h300, 32'h0000_0001);
        rd(12'h5F0, 32'h1, 11);                 // R11 locked write flagged
        rd(12'h300, 32'h0000_0001, 11);         // R11 write still applied
        wr(12'h000, MAGIC);
        rd(12'h000, 32'h1, 1);                  // R1 magic unlocks
        rd(12'h5F0, 32'h1, 11);                 // R11 sticky
        wr(12'h5F0, 32'h0);
        rd(12'h5F0, 32'h1, 7);                  // R7 status not writable

        // R6 random word
        model = 32'h1;
        for (int k = 0; k < 3; k++) begin
            rd(12'h540, model, 6);
            model = lfsr_next(model);
        end
        wr(12'h540, 32'h0);                     // R7 write ignored, no advance
        wr(12'h524, 32'h0);
        rd(12'h540, model, 6);                  // R6 enable word irrelevant
        model = lfsr_next(model);
        wr(12'h524, 32'h1);
        rd(12'h540, model, 6);

        // second reset with key input low
        key_state_in = 1'b0;
        do_reset();
        rd(12'h000, 32'h0, 9);                  // R9 key from input
        rd(12'h540, 32'h1, 6);                  // R6 reseeded
        rd(12'h300, 32'h0, 8);                  // R8 cleared
        rd(12'h5F0, 32'h0, 11);                 // R11 cleared by reset
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule